// File: doc/BRIEF.md
# Five-Level Hybrid PWM Gate Generator

This block drives one phase leg of a five-level inverter built from two cascaded H-bridge cells. Each accepted sample of a signed sinusoidal reference is sliced against a single internal triangular carrier. The slicer also uses a copy of that carrier lifted by one carrier peak. The result is one of five leg levels, from -2 to +2 cell-supply units. The chosen level is then turned into eight registered switch states: the first cell's four switches in bits 7..4, the second cell's in bits 3..0, with switch 1 in the highest bit of each nibble.

Sign changes of the reference clock a chain of three toggle stages. These give square waves at the fundamental rate, at half of it and at a quarter of it. The fundamental wave marks the half-cycle, so the output cell switches at the fundamental rate while the other cell runs at the carrier rate. The half-rate wave alternates between the two switch patterns that make zero volts, so each switch pair takes the clamping duty in turn. The quarter-rate wave exchanges the two cells, so both cells carry the same loss over time.

The carrier advances once every `STEP_DIV` accepted samples and runs between 0 and `PEAK`. With a sample strobe every cycle at 125 MHz, `PEAK`=1023 and `STEP_DIV`=20 give a carrier of about 3 kHz.

Top module: `fivelevel_gate_gen`

## Requirements
- R1: While reset is high, and in the cycle after it is released with no sample, `gate` is 8'b1100_0011, `level` is 0, `carrier` is 0 and the three rate flags are 0.
- R2: The carrier starts at 0, rising. On every `STEP_DIV`-th accepted sample it moves by one: up to `PEAK`, then down to 0, then up again. `carrier` always stays within 0..`PEAK`.
- R3: For an accepted sample, let m = |ref| and c = the carrier value before that sample's step. `level` is ±2 when m > c+`PEAK`, ±1 when m > c, and 0 otherwise. The level is negative exactly when ref < 0.
- R4: With `rate_quarter`=0, level +2 gives 8'b1010_1010, +1 gives 8'b1010_0000, -1 gives 8'b0101_0000 and -2 gives 8'b0101_0101.
- R5: Level 0 gives 8'b1100_0011 when `rate_half`=0 and 8'b0011_0000 when `rate_half`=1, before any cell swap.
- R6: `rate_fm` toggles on each accepted sample whose sign differs from that of the previous accepted sample. Zero counts as positive, and before the first sample the sign is taken as positive.
- R7: `rate_half` toggles when `rate_fm` goes 0→1. `rate_quarter` toggles when `rate_half` goes 0→1. Both change in the same cycle as the stage that clocks them.
- R8: When `rate_quarter`=1, the upper and lower nibbles of the vector from R4/R5 are exchanged.
- R9: A cycle with `smp_valid` low changes none of `gate`, `level`, `carrier` or the rate flags, whatever `smp_ref` holds.
- R10: All outputs for an accepted sample appear one clock after the edge on which `smp_valid` is high. Until that edge they keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_valid | input | 1 | Strobe: `smp_ref` holds a new sample |
| smp_ref | input | REF_W | Signed reference sample |
| gate | output | 8 | Switch states, first cell S1..S4 in bits 7..4, second cell S1..S4 in bits 3..0 |
| level | output | 3 | Signed leg level, -2..+2 |
| carrier | output | CW | Current triangular carrier value |
| rate_fm | output | 1 | Fundamental-rate square wave |
| rate_half | output | 1 | Half-rate square wave |
| rate_quarter | output | 1 | Quarter-rate square wave (cell swap) |

## Verification
The bench builds the block with `REF_W`=8, `PEAK`=4 and `STEP_DIV`=2. A full carrier period is then sixteen samples, so the prescaler and both turning points of the carrier come up many times in a short run. With a small peak, exact equality of the reference with c and with c+`PEAK` can be forced at known carrier values. A sine with an amplitude of two peaks gives all five levels. Eight fundamental periods cover every combination of zero-state pattern and cell swap. The most negative 8-bit code checks the magnitude path at its edge.

// File: rtl/fl_pkg.sv
package fl_pkg;
    localparam logic [7:0] GV_POS2  = 8'b1010_1010;
    localparam logic [7:0] GV_POS1  = 8'b1010_0000;
    localparam logic [7:0] GV_NEG1  = 8'b0101_0000;
    localparam logic [7:0] GV_NEG2  = 8'b0101_0101;
    localparam logic [7:0] GV_ZERO0 = 8'b1100_0011;
    localparam logic [7:0] GV_ZERO1 = 8'b0011_0000;

    function automatic logic [7:0] swap_cells(input logic [7:0] v);
        return {v[3:0], v[7:4]};
    endfunction
endpackage

// File: rtl/fl_carrier.sv
module fl_carrier #(
    parameter int PEAK     = 1023,
    parameter int STEP_DIV = 20,
    parameter int CW       = $clog2(PEAK + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          step_en,
    output logic [CW-1:0] carrier_q
);
    localparam int PW = (STEP_DIV > 1) ? $clog2(STEP_DIV) : 1;

    typedef struct packed {
        logic [PW-1:0] pre;
        logic          up;
        logic [CW-1:0] cnt;
    } car_t;

    car_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (step_en) begin
            if (s_q.pre == PW'(STEP_DIV - 1)) begin
                s_d.pre = '0;
                if (s_q.up) begin
                    s_d.cnt = s_q.cnt + 1'b1;
                    if (s_d.cnt == CW'(PEAK)) s_d.up = 1'b0;
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                    if (s_d.cnt == '0) s_d.up = 1'b1;
                end
            end else begin
                s_d.pre = s_q.pre + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q.pre <= '0;
            s_q.up  <= 1'b1;
            s_q.cnt <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign carrier_q = s_q.cnt;
endmodule

// File: rtl/fl_rate_chain.sv
module fl_rate_chain #(
    parameter int STAGES = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              smp_valid,
    input  logic              smp_neg,
    output logic [STAGES-1:0] rate_d,
    output logic [STAGES-1:0] rate_q
);
    typedef struct packed {
        logic              neg;
        logic [STAGES-1:0] rate;
    } rc_t;

    rc_t s_d, s_q;
    logic [STAGES-1:0] fire;

    assign fire[0] = smp_valid && (smp_neg != s_q.neg);

    for (genvar k = 0; k < STAGES; k++) begin : g_stage
        assign rate_d[k] = s_q.rate[k] ^ fire[k];
        if (k < STAGES - 1) begin : g_link
            // next stage is clocked by this stage's rising edge
            assign fire[k+1] = fire[k] && !s_q.rate[k];
        end
    end

    always_comb begin
        s_d      = s_q;
        s_d.rate = rate_d;
        if (smp_valid) s_d.neg = smp_neg;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rate_q = s_q.rate;
endmodule

// File: rtl/fl_level_slicer.sv
module fl_level_slicer #(
    parameter int REF_W = 12,
    parameter int PEAK  = 1023,
    parameter int CW    = $clog2(PEAK + 1)
) (
    input  logic signed [REF_W-1:0] smp_ref,
    input  logic        [CW-1:0]    carrier,
    output logic signed [2:0]       level
);
    localparam int CMP_W = ((REF_W > CW) ? REF_W : CW) + 2;

    logic              neg;
    logic [REF_W-1:0]  mag;
    logic [CMP_W-1:0]  mag_x, low_x, high_x;
    logic [1:0]        step;

    always_comb begin
        neg    = smp_ref[REF_W-1];
        mag    = neg ? (~smp_ref + 1'b1) : smp_ref;
        mag_x  = {{(CMP_W-REF_W){1'b0}}, mag};
        low_x  = {{(CMP_W-CW){1'b0}}, carrier};
        high_x = low_x + CMP_W'(PEAK);
        if (mag_x > high_x)     step = 2'd2;
        else if (mag_x > low_x) step = 2'd1;
        else                    step = 2'd0;
        level = neg ? -$signed({1'b0, step}) : $signed({1'b0, step});
    end
endmodule

// File: rtl/fl_gate_map.sv
module fl_gate_map (
    input  logic signed [2:0] level,
    input  logic              zero_alt,
    input  logic              cell_swap,
    output logic [7:0]        gate
);
    import fl_pkg::*;

    logic [7:0] base;

    always_comb begin
        unique case (level)
            3'sd2:   base = GV_POS2;
            3'sd1:   base = GV_POS1;
            -3'sd1:  base = GV_NEG1;
            -3'sd2:  base = GV_NEG2;
            default: base = zero_alt ? GV_ZERO1 : GV_ZERO0;
        endcase
        gate = cell_swap ? swap_cells(base) : base;
    end
endmodule

// File: rtl/fivelevel_gate_gen.sv
module fivelevel_gate_gen #(
    parameter int REF_W    = 12,
    parameter int PEAK     = 1023,
    parameter int STEP_DIV = 20,
    parameter int CW       = $clog2(PEAK + 1)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    smp_valid,
    input  logic signed [REF_W-1:0] smp_ref,
    output logic [7:0]              gate,
    output logic signed [2:0]       level,
    output logic [CW-1:0]           carrier,
    output logic                    rate_fm,
    output logic                    rate_half,
    output logic                    rate_quarter
);
    import fl_pkg::*;

    localparam int STAGES = 3;

    typedef struct packed {
        logic [7:0]        gate;
        logic signed [2:0] level;
    } out_t;

    out_t o_d, o_q;
    logic [STAGES-1:0] rate_d, rate_q;
    logic signed [2:0] lvl_w;
    logic [7:0]        gate_w;

    fl_carrier #(.PEAK(PEAK), .STEP_DIV(STEP_DIV), .CW(CW)) u_carrier (
        .clk       (clk),
        .rst       (rst),
        .step_en   (smp_valid),
        .carrier_q (carrier)
    );

    fl_rate_chain #(.STAGES(STAGES)) u_rates (
        .clk       (clk),
        .rst       (rst),
        .smp_valid (smp_valid),
        .smp_neg   (smp_ref[REF_W-1]),
        .rate_d    (rate_d),
        .rate_q    (rate_q)
    );

    fl_level_slicer #(.REF_W(REF_W), .PEAK(PEAK), .CW(CW)) u_slicer (
        .smp_ref (smp_ref),
        .carrier (carrier),
        .level   (lvl_w)
    );

    fl_gate_map u_map (
        .level     (lvl_w),
        .zero_alt  (rate_d[1]),
        .cell_swap (rate_d[2]),
        .gate      (gate_w)
    );

    always_comb begin
        o_d = o_q;
        if (smp_valid) begin
            o_d.gate  = gate_w;
            o_d.level = lvl_w;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            o_q.gate  <= GV_ZERO0;
            o_q.level <= '0;
        end else begin
            o_q <= o_d;
        end
    end

    assign gate         = o_q.gate;
    assign level        = o_q.level;
    assign rate_fm      = rate_q[0];
    assign rate_half    = rate_q[1];
    assign rate_quarter = rate_q[2];
endmodule

// File: rtl/fl_gate_gen_chk.sv
module fl_gate_gen_chk #(
    parameter int PEAK = 1023,
    parameter int CW   = $clog2(PEAK + 1)
) (
    input logic              clk,
    input logic              rst,
    input logic              smp_valid,
    input logic [7:0]        gate,
    input logic signed [2:0] level,
    input logic [CW-1:0]     carrier,
    input logic              rate_fm,
    input logic              rate_half,
    input logic              rate_quarter
);
    AST_RESET_STATE: assert property (@(posedge clk) rst |=> (gate == 8'hC3 && level == 3'sd0 && carrier == '0 && !rate_fm && !rate_half && !rate_quarter)); // R1
    AST_CARRIER_RANGE: assert property (@(posedge clk) disable iff (rst) carrier <= CW'(PEAK)); // R2
    AST_CARRIER_STEP: assert property (@(posedge clk) disable iff (rst) !$stable(carrier) |-> ($past(smp_valid) && ((carrier == $past(carrier) + 1'b1) || (carrier == $past(carrier) - 1'b1)))); // R2
    AST_LEVEL_RANGE: assert property (@(posedge clk) disable iff (rst) (level >= -3'sd2 && level <= 3'sd2)); // R3
    AST_POS2_VEC: assert property (@(posedge clk) disable iff (rst) (level == 3'sd2) |-> (gate == 8'hAA)); // R4
    AST_NEG2_VEC: assert property (@(posedge clk) disable iff (rst) (level == -3'sd2) |-> (gate == 8'h55)); // R4
    AST_ONE_VEC: assert property (@(posedge clk) disable iff (rst) (level == 3'sd1) |-> (gate == (rate_quarter ? 8'h0A : 8'hA0))); // R8
    AST_ZERO_VEC: assert property (@(posedge clk) disable iff (rst) (level == 3'sd0) |-> (gate == (rate_half ? (rate_quarter ? 8'h03 : 8'h30) : (rate_quarter ? 8'h3C : 8'hC3)))); // R5
    AST_FM_ON_SAMPLE: assert property (@(posedge clk) disable iff (rst) !$stable(rate_fm) |-> $past(smp_valid)); // R6
    AST_HALF_CLOCKED: assert property (@(posedge clk) disable iff (rst) !$stable(rate_half) |-> $rose(rate_fm)); // R7
    AST_QUARTER_CLOCKED: assert property (@(posedge clk) disable iff (rst) !$stable(rate_quarter) |-> $rose(rate_half)); // R7
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst) !smp_valid |=> ($stable(gate) && $stable(level) && $stable(carrier) && $stable(rate_fm))); // R9
endmodule

bind fivelevel_gate_gen fl_gate_gen_chk #(.PEAK(PEAK), .CW(CW)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .smp_valid    (smp_valid),
    .gate         (gate),
    .level        (level),
    .carrier      (carrier),
    .rate_fm      (rate_fm),
    .rate_half    (rate_half),
    .rate_quarter (rate_quarter)
);

// File: tb/fivelevel_gate_gen_test.sv
module fivelevel_gate_gen_test;
    localparam int REF_W    = 8;
    localparam int PEAK     = 4;
    localparam int STEP_DIV = 2;
    localparam int CW       = $clog2(PEAK + 1);

    logic                    clk = 1'b0;
    logic                    rst = 1'b1;
    logic                    smp_valid = 1'b0;
    logic signed [REF_W-1:0] smp_ref = '0;
    logic [7:0]              gate;
    logic signed [2:0]       level;
    logic [CW-1:0]           carrier;
    logic                    rate_fm, rate_half, rate_quarter;

    int checks = 0;
    int fails  = 0;

    // bench model state
    int m_c, m_up, m_pre, m_neg, m_t1, m_t2, m_t3, m_lvl;
    logic [7:0] m_gate;

    always #4 clk = ~clk;

    fivelevel_gate_gen #(.REF_W(REF_W), .PEAK(PEAK), .STEP_DIV(STEP_DIV)) uut (
        .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_ref(smp_ref),
        .gate(gate), .level(level), .carrier(carrier),
        .rate_fm(rate_fm), .rate_half(rate_half), .rate_quarter(rate_quarter)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model_reset();
        m_c = 0; m_up = 1; m_pre = 0; m_neg = 0;
        m_t1 = 0; m_t2 = 0; m_t3 = 0; m_lvl = 0; m_gate = 8'b1100_0011;
    endtask

    function automatic logic [7:0] vec_of(input int lv, input int half, input int quarter);
        logic [7:0] b;
        case (lv)
            2:  b = 8'b1010_1010;
            1:  b = 8'b1010_0000;
            -1: b = 8'b0101_0000;
            -2: b = 8'b0101_0101;
            default: b = half ? 8'b0011_0000 : 8'b1100_0011;
        endcase
        return quarter ? {b[3:0], b[7:4]} : b;
    endfunction

    task automatic check_all(input string tag);
        check({tag, " R3 level"}, level, m_lvl);
        check({tag, " R4/R5/R8 gate"}, gate, m_gate);
        check({tag, " R2 carrier"}, carrier, m_c);
        check({tag, " R6 rate_fm"}, rate_fm, m_t1);
        check({tag, " R7 rate_half"}, rate_half, m_t2);
        check({tag, " R7 rate_quarter"}, rate_quarter, m_t3);
    endtask

    // Called at a negedge; returns at the following negedge.
    task automatic apply(input int r);
        int mag, lv, neg, o1, o2;
        logic [7:0] prev_gate;
        prev_gate = gate;
        smp_ref   = REF_W'(r);
        smp_valid = 1'b1;
        neg = (r < 0) ? 1 : 0;
        mag = (r < 0) ? -r : r;
        if (mag > m_c + PEAK) lv = 2;
        else if (mag > m_c)   lv = 1;
        else                  lv = 0;
        if (neg != 0) lv = -lv;
        if (neg != m_neg) begin
            o1 = m_t1; m_t1 = 1 - m_t1;
            if (o1 == 0 && m_t1 == 1) begin
                o2 = m_t2; m_t2 = 1 - m_t2;
                if (o2 == 0 && m_t2 == 1) m_t3 = 1 - m_t3;
            end
        end
        m_neg = neg;
        m_lvl = lv;
        m_gate = vec_of(lv, m_t2, m_t3);
        if (m_pre == STEP_DIV - 1) begin
            m_pre = 0;
            if (m_up != 0) begin m_c++; if (m_c == PEAK) m_up = 0; end
            else begin m_c--; if (m_c == 0) m_up = 1; end
        end else begin
            m_pre++;
        end
        #1;
        check("R10 pre-edge gate", gate, prev_gate);
        @(posedge clk);
        #2 smp_valid = 1'b0;
        @(negedge clk);
        check_all("sample");
    endtask

    task automatic t_reset();
        rst = 1'b1;
        model_reset();
        repeat (3) @(negedge clk);
        check("R1 reset gate", gate, 8'hC3);
        rst = 1'b0;
        @(negedge clk);
        check_all("R1 after reset");
    endtask

    task automatic t_positive();
        // steady positive values across two carrier periods
        for (int i = 0; i < 32; i++) apply((i % 10));
        apply(0);
        check("R5 zero unswapped", gate, 8'hC3);
    endtask

    task automatic t_boundary();
        // equality with c and c+PEAK must not reach the next level
        for (int i = 0; i < 8; i++) begin
            apply(m_c);
            check("R3 equal carrier gives 0", level, 0);
            apply(m_c + PEAK);
            check("R3 equal raised carrier gives 1", level, 1);
            apply(m_c + PEAK + 1);
            check("R3 above raised carrier gives 2", level, 2);
        end
    endtask

    task automatic t_negative();
        apply(-100);
        check("R3 -2 on negative", level, -2);
        check("R7 first crossing raises quarter", rate_quarter, 1);
        check("R8 swapped -2 vector", gate, 8'h55);
        apply(-128);
        check("R3 most negative code", level, -2);
        apply(-1);
        apply(5);
        check("R6 toggle back", rate_fm, 0);
    endtask

    task automatic t_sine();
        for (int p = 0; p < 8; p++) begin
            for (int s = 0; s < 24; s++) begin
                real ph;
                ph = 6.283185307 * real'(s) / 24.0;
                apply($rtoi(8.0 * $sin(ph)));
            end
        end
    endtask

    task automatic t_idle();
        logic [7:0] g0;
        int l0, c0;
        g0 = gate; l0 = level; c0 = carrier;
        for (int i = 0; i < 6; i++) begin
            smp_ref = REF_W'((i % 2 == 0) ? -77 : 90);
            @(negedge clk);
            check("R9 idle gate", gate, g0);
            check("R9 idle level", level, l0);
            check("R9 idle carrier", carrier, c0);
            check("R9 idle rate_fm", rate_fm, m_t1);
        end
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_positive();
                t_boundary();
                t_negative();
                t_idle();
                t_sine();
                t_idle();
            end
            begin
                repeat (150000) @(posedge clk);
                fails++;
                checks++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule